// File: doc/BRIEF.md
# Bus Access Ordering Guard

This block sits between a pipelined processor's access stream and a single-issue memory bus. Writes are posted into a small in-order queue, so the processor does not wait for them. Reads are urgent. In ordinary address space, a read that is presented together with, or after, still-queued writes to other addresses is sent to the bus ahead of them. Reads therefore see no added latency.

Some address windows hold devices where the order of side effects matters. Each window is a base/limit pair, and each has an enable bit. When an access falls in an enabled window, the guard keeps the read behind every older queued write. While it does so it raises a busy flag toward the processor until those writes have been accepted by the bus. A read whose address matches a queued write is never moved ahead of that write, whatever the window settings. At reset, every window is enabled.

The processor must not present requests while busy is high. The bus side is a valid/ready port whose outputs come from registers. Read data is captured when a read is accepted, and it is returned on the following cycle.

Top module: `order_guard`

## Requirements
- R1: After reset, bus_valid, cpu_busy and cpu_rvalid are 0, and all protection windows are enabled.
- R2: Suppose a write and a read to different addresses are presented together, and neither address lies in an enabled window. The read is then on the bus (bus_valid=1, bus_we=0) in the cycle after the request, and the write follows it.
- R3: If either address of such a pair lies in an enabled window, the write reaches the bus before the read.
- R4: When a read is held back by ordering, cpu_busy is 1 from the cycle after the request until the held read has been moved to the bus. Requests presented while cpu_busy is 1 are ignored and produce no bus transaction.
- R5: A read to the same address as an older queued write is issued after that write, even with every window disabled.
- R6: A pulse on cfg_we loads cfg_zone_en into the window enable register, where bit i enables window i. Window i covers ZONE_BASE[i] through ZONE_LIMIT[i], with both ends included. An access in a disabled window is treated as unprotected.
- R7: While bus_valid=1 and bus_ready=0, bus_valid, bus_we, bus_addr and bus_wdata stay unchanged.
- R8: One cycle after a read is accepted (bus_valid, !bus_we, bus_ready), cpu_rvalid=1 and cpu_rdata holds the bus_rdata of that acceptance. cpu_rvalid is 0 in every other cycle.
- R9: Writes reach the bus in the order they were requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the window enable register |
| cfg_zone_en | input | NZONE | New window enables, bit i for window i |
| wr_req | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_req | input | 1 | Read request |
| rd_addr | input | AW | Read address |
| cpu_busy | output | 1 | Requests are not accepted this cycle |
| cpu_rdata | output | DW | Returned read data |
| cpu_rvalid | output | 1 | cpu_rdata is valid |
| bus_valid | output | 1 | Bus transaction presented |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Bus accepts the transaction |
| bus_rdata | input | DW | Bus read data, valid during a read acceptance |

## Verification
A read that may overtake leaves on the bus register one edge after its request, with its write one edge later. A held pair costs two cycles of busy: the write appears one edge after the request, the read two edges after, and busy falls at that same edge. The bench changes inputs on the falling edge. It checks busy and the bypassing read at the falling edge right after the request edge. It checks the logged transaction order and the returned data only after five further cycles, when both accesses and cpu_rvalid are due to have completed.

// File: rtl/oguard_pkg.sv
package oguard_pkg;
  typedef enum logic [1:0] {
    ISS_NONE  = 2'd0,
    ISS_WRITE = 2'd1,
    ISS_RBUF  = 2'd2,
    ISS_RNEW  = 2'd3
  } issue_e;
endpackage

// File: rtl/oguard_zone_match.sv
module oguard_zone_match #(
  parameter int AW    = 16,
  parameter int NZONE = 2,
  parameter logic [NZONE*AW-1:0] ZONE_BASE  = '0,
  parameter logic [NZONE*AW-1:0] ZONE_LIMIT = '0
) (
  input  logic [AW-1:0]    addr,
  input  logic [NZONE-1:0] zone_en,
  output logic             hit
);
  logic [NZONE-1:0] in_zone;

  for (genvar z = 0; z < NZONE; z++) begin : g_zone
    assign in_zone[z] = zone_en[z]
                     && (addr >= ZONE_BASE[z*AW +: AW])
                     && (addr <= ZONE_LIMIT[z*AW +: AW]);
  end

  assign hit = |in_zone;
endmodule

// File: rtl/oguard_wqueue.sv
module oguard_wqueue #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          push_prot,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] chk_addr,
  output logic          conflict
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] prot_q;
  logic [DEPTH-1:0] vld_q;
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] blocks;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wptr] <= push_addr;
      data_q[wptr] <= push_data;
      prot_q[wptr] <= push_prot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
    end else begin
      if (push) begin
        vld_q[wptr] <= 1'b1;
        wptr        <= step(wptr);
      end
      if (pop) begin
        vld_q[rptr] <= 1'b0;
        rptr        <= step(rptr);
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign blocks[i] = vld_q[i] && (prot_q[i] || (addr_q[i] == chk_addr));
  end

  assign conflict  = |blocks;
  assign head_addr = addr_q[rptr];
  assign head_data = data_q[rptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
endmodule

// File: rtl/order_guard.sv
module order_guard
  import oguard_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 16,
  parameter int NZONE  = 2,
  parameter int QDEPTH = 4,
  parameter logic [NZONE*AW-1:0] ZONE_BASE  = {16'h6000, 16'h4000},
  parameter logic [NZONE*AW-1:0] ZONE_LIMIT = {16'h6FFF, 16'h4FFF}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [NZONE-1:0] cfg_zone_en,
  input  logic             wr_req,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic             cpu_busy,
  output logic [DW-1:0]    cpu_rdata,
  output logic             cpu_rvalid,
  output logic             bus_valid,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic             bus_ready,
  input  logic [DW-1:0]    bus_rdata
);
  logic [NZONE-1:0] zone_en;
  logic             rbuf_v;
  logic [AW-1:0]    rbuf_addr;
  logic             wr_prot, rd_prot;
  logic             wr_fire, rd_fire;
  logic             q_empty, q_full, q_conflict, q_pop;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_data;
  logic             slot_free, rd_blocked;
  issue_e           issue;

  oguard_zone_match #(.AW(AW), .NZONE(NZONE), .ZONE_BASE(ZONE_BASE),
                      .ZONE_LIMIT(ZONE_LIMIT)) u_wzone (
    .addr(wr_addr), .zone_en(zone_en), .hit(wr_prot));

  oguard_zone_match #(.AW(AW), .NZONE(NZONE), .ZONE_BASE(ZONE_BASE),
                      .ZONE_LIMIT(ZONE_LIMIT)) u_rzone (
    .addr(rd_addr), .zone_en(zone_en), .hit(rd_prot));

  oguard_wqueue #(.AW(AW), .DW(DW), .DEPTH(QDEPTH)) u_queue (
    .clk(clk), .rst(rst),
    .push(wr_fire), .push_addr(wr_addr), .push_data(wr_data), .push_prot(wr_prot),
    .pop(q_pop), .head_addr(q_addr), .head_data(q_data),
    .empty(q_empty), .full(q_full),
    .chk_addr(rd_addr), .conflict(q_conflict));

  assign cpu_busy  = rbuf_v || q_full;
  assign wr_fire   = wr_req && !cpu_busy;
  assign rd_fire   = rd_req && !cpu_busy;
  assign slot_free = !bus_valid || bus_ready;

  // A new read must wait when any older write is protected, when the read
  // itself is protected and an older write exists, or on an address match.
  assign rd_blocked = q_conflict
                   || (rd_prot && (!q_empty || wr_fire))
                   || (wr_fire && (wr_prot || (wr_addr == rd_addr)));

  always_comb begin
    issue = ISS_NONE;
    if (slot_free) begin
      if (rbuf_v)                      issue = q_empty ? ISS_RBUF : ISS_WRITE;
      else if (rd_fire && !rd_blocked) issue = ISS_RNEW;
      else if (!q_empty)               issue = ISS_WRITE;
    end
  end

  assign q_pop = (issue == ISS_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      zone_en    <= '1;
      rbuf_v     <= 1'b0;
      rbuf_addr  <= '0;
      bus_valid  <= 1'b0;
      bus_we     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      if (cfg_we) zone_en <= cfg_zone_en;

      if (rd_fire && issue != ISS_RNEW) begin
        rbuf_v    <= 1'b1;
        rbuf_addr <= rd_addr;
      end else if (issue == ISS_RBUF) begin
        rbuf_v <= 1'b0;
      end

      if (slot_free) begin
        bus_valid <= (issue != ISS_NONE);
        case (issue)
          ISS_WRITE: begin bus_we <= 1'b1; bus_addr <= q_addr;    bus_wdata <= q_data; end
          ISS_RBUF:  begin bus_we <= 1'b0; bus_addr <= rbuf_addr; bus_wdata <= '0;     end
          ISS_RNEW:  begin bus_we <= 1'b0; bus_addr <= rd_addr;   bus_wdata <= '0;     end
          default:   begin bus_we <= 1'b0; end
        endcase
      end

      cpu_rvalid <= bus_valid && !bus_we && bus_ready;
      if (bus_valid && !bus_we && bus_ready) cpu_rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/order_guard_chk.sv
module order_guard_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_busy,
  input logic          cpu_rvalid,
  input logic [DW-1:0] cpu_rdata,
  input logic          bus_valid,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ready,
  input logic [DW-1:0] bus_rdata
);
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!bus_valid && !cpu_busy && !cpu_rvalid));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

  a_r8_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_ready) |=> (cpu_rvalid && cpu_rdata == $past(bus_rdata)));

  a_r8_rvalid_only_after_read: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> $past(bus_valid && !bus_we && bus_ready));
endmodule

bind order_guard order_guard_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid),
  .cpu_rdata(cpu_rdata), .bus_valid(bus_valid), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata));

// File: tb/sim_order_guard.sv
module sim_order_guard;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_zone_en = 2'b11;
  logic        wr_req = 1'b0, rd_req = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic        cpu_busy, cpu_rvalid, bus_valid, bus_we;
  logic [15:0] cpu_rdata, bus_addr, bus_wdata, bus_rdata;
  logic        bus_ready = 1'b1;

  int compared = 0, mismatched = 0, nlog = 0;
  bit done = 1'b0;
  logic        log_we   [8];
  logic [15:0] log_addr [8];
  logic [15:0] last_rdata = '0;

  always #(CLK_P/2) clk = ~clk;
  assign bus_rdata = bus_addr ^ 16'hA5A5;

  order_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_zone_en(cfg_zone_en),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .cpu_busy(cpu_busy),
    .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata));

  always @(negedge clk) begin
    if (bus_valid && bus_ready) begin
      if (nlog < 8) begin
        log_we[nlog]   = bus_we;
        log_addr[nlog] = bus_addr;
      end
      nlog = nlog + 1;
    end
    if (cpu_rvalid) last_rdata = cpu_rdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {write addr, read addr, read goes first, busy expected}
  localparam logic [33:0] VEC [8] = '{
    {16'h1000, 16'h2000, 1'b1, 1'b0},   // R2 plain space
    {16'h4010, 16'h2000, 1'b0, 1'b1},   // R3 write in window 0
    {16'h1000, 16'h6020, 1'b0, 1'b1},   // R3 read in window 1
    {16'h3000, 16'h3000, 1'b0, 1'b1},   // R5 same address
    {16'h4FFF, 16'h5000, 1'b0, 1'b1},   // R6 limit included
    {16'h3FFF, 16'h5000, 1'b1, 1'b0},   // R6 just below base
    {16'h7000, 16'h6FFF, 1'b0, 1'b1},   // R6 read on limit
    {16'h7000, 16'h1234, 1'b1, 1'b0}    // R2
  };

  task automatic run_pair(input logic [15:0] wa, input logic [15:0] ra,
                          input bit rf, input bit bz, input string req);
    @(negedge clk);
    nlog = 0;
    wr_req = 1'b1; wr_addr = wa; wr_data = wa + 16'd1;
    rd_req = 1'b1; rd_addr = ra;
    @(negedge clk);
    wr_req = 1'b0; rd_req = 1'b0;
    chk(cpu_busy == bz, {req, " R4 busy"}, cpu_busy, bz);
    if (rf) chk(bus_valid && !bus_we && bus_addr == ra, "R2 read on bus next cycle", bus_addr, ra);
    repeat (5) @(negedge clk);
    chk(nlog == 2, {req, " count"}, nlog, 2);
    chk(log_we[0] == !rf, {req, " first kind"}, log_we[0], !rf);
    chk(log_addr[0] == (rf ? ra : wa), {req, " first addr"}, log_addr[0], rf ? ra : wa);
    chk(log_addr[1] == (rf ? wa : ra), {req, " second addr"}, log_addr[1], rf ? wa : ra);
    chk(last_rdata == (ra ^ 16'hA5A5), "R8 read data", last_rdata, ra ^ 16'hA5A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!bus_valid && !cpu_busy && !cpu_rvalid, "R1 reset idle",
        {bus_valid, cpu_busy, cpu_rvalid}, 0);

    for (int i = 0; i < 8; i++) begin
      logic [15:0] wa, ra;
      wa = VEC[i][33:18];
      ra = VEC[i][17:2];
      run_pair(wa, ra, VEC[i][1], VEC[i][0],
               (wa == ra) ? "R5" : (VEC[i][1] ? "R2" : "R3"));
    end

    // R6: disable window 0 only
    @(negedge clk); cfg_we = 1'b1; cfg_zone_en = 2'b10;
    @(negedge clk); cfg_we = 1'b0;
    run_pair(16'h4010, 16'h2000, 1'b1, 1'b0, "R6 window0 off");
    run_pair(16'h1000, 16'h6020, 1'b0, 1'b1, "R6 window1 on");
    // R5 with every window disabled
    @(negedge clk); cfg_we = 1'b1; cfg_zone_en = 2'b00;
    @(negedge clk); cfg_we = 1'b0;
    run_pair(16'h4444, 16'h4444, 1'b0, 1'b1, "R5 all off");
    @(negedge clk); cfg_we = 1'b1; cfg_zone_en = 2'b11;
    @(negedge clk); cfg_we = 1'b0;

    // R4: stall length and ignored request while busy
    @(negedge clk);
    nlog = 0;
    wr_req = 1'b1; wr_addr = 16'h4100; wr_data = 16'h0042;
    rd_req = 1'b1; rd_addr = 16'h0200;
    @(negedge clk);
    wr_req = 1'b0; rd_addr = 16'h2222;
    chk(cpu_busy, "R4 busy first cycle", cpu_busy, 1);
    @(negedge clk);
    rd_req = 1'b0;
    chk(cpu_busy, "R4 busy second cycle", cpu_busy, 1);
    @(negedge clk);
    chk(!cpu_busy, "R4 busy released", cpu_busy, 0);
    repeat (5) @(negedge clk);
    chk(nlog == 2, "R4 ignored read", nlog, 2);

    // R9: back-to-back writes
    @(negedge clk);
    nlog = 0;
    wr_req = 1'b1; wr_addr = 16'h0A00; wr_data = 16'h1111;
    @(negedge clk);
    wr_addr = 16'h0B00; wr_data = 16'h2222;
    @(negedge clk);
    wr_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(nlog == 2 && log_addr[0] == 16'h0A00 && log_addr[1] == 16'h0B00,
        "R9 write order", {log_addr[0], log_addr[1]}, {16'h0A00, 16'h0B00});

    // R7: bus stalls with ready low
    @(negedge clk);
    nlog = 0;
    bus_ready = 1'b0;
    wr_req = 1'b1; wr_addr = 16'h0C00; wr_data = 16'h3333;
    @(negedge clk);
    wr_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_valid && bus_we && bus_addr == 16'h0C00 && bus_wdata == 16'h3333,
        "R7 held while not ready", bus_addr, 16'h0C00);
    chk(nlog == 0, "R7 nothing accepted", nlog, 0);
    bus_ready = 1'b1;
    @(negedge clk);
    chk(nlog == 1 && log_addr[0] == 16'h0C00, "R7 accepted after ready", nlog, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule